// File: doc/BRIEF.md
# Alarm and Timer Controller

This block sits beside a real-time clock's BCD counting chain. It holds the main control/status register, the alarm-control register and the bank of alarm compare registers. It watches the live time counters and, when the configured fields agree, latches an alarm flag. The clock can be matched by time of day only, by time of day plus date and month, or by time of day on selected weekdays.

It also runs a two-digit BCD timer. The timer advances on a chosen time-unit tick and raises a timer flag when it rolls over. An optional timer match also raises the alarm flag. Both flags are sticky and are cleared only by a register write. They drive an active-low, open-drain interrupt, which is modelled here as a pull-down enable.

While alarms are switched off, the interrupt pin carries a free-running 1 Hz square wave for calibration. The flag bits then read back as seconds and minutes phase indicators.

Register addresses (4-bit): 0 control/status, 7 timer, 8 alarm control, 9..15 alarm registers (hundredths, seconds, minutes, hours, date, weekday/month, timer). Every alarm register sits 8 above the counter it is compared with.

Top module: `alarm_timer_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `irq_oe` is 0; addresses 1 to 6 always read 0x00.
- R2: Control/status bits are: 0 timer flag, 1 alarm flag, 2 alarm enable, 3 mask, 5:4 mode, 6 hold, 7 stop. With alarm enable set, a written control value reads back unchanged. Alarm control (addr 8) and alarm registers (addr 9..15) read back what was written.
- R3: While alarm enable (bit 2) is 0, `irq_oe` starts at 0 and toggles after every 50 `tick_hsec` pulses. Status bit 0 shows the same phase, and status bit 1 toggles after every 30 `tick_sec` pulses.
- R4: Alarm-control bits 2:0 choose the timer tick: 001 hundredths, 010 seconds, 011 minutes, 100 hours, 101 days; 000, 110 and 111 stop it. On each chosen tick the timer (addr 7) advances by one in two-digit BCD, and the other ticks are ignored.
- R5: A tick at timer value 0x99 sets the timer to 0x00 and sets status bit 0 in the same clock edge.
- R6: A write to address 7 loads the timer and takes priority over a tick in the same cycle.
- R7: With alarm-control bits 5:4 = 01 (daily), the alarm flag sets one cycle after hundredths, seconds, minutes and hours (all 8 bits) equal registers 9..12. Date and month are ignored.
- R8: With bits 5:4 = 11 (dated), the daily fields must match, and so must counter date bits 5:0 against reg 13 bits 5:0 and counter month bits 4:0 against reg 14 bits 4:0. Year (date bits 7:6) and weekday (month-register bits 7:5) are ignored.
- R9: With bits 5:4 = 10 (weekday), the daily fields must match and reg 14 bit w must be 1, where w is counter weekday/month bits 7:5.
- R10: With alarm-control bit 6 set, the alarm flag sets one cycle after the timer becomes equal to reg 15.
- R11: Flags stay set until a control write clears them. A match that persists does not set the flag again. A flag-setting event in the same cycle as a clearing write wins.
- R12: With alarm enable set, `irq_oe` is 1 exactly when (alarm flag and alarm-control bit 7) or (timer flag and alarm-control bit 3).
- R13: While alarm enable is 0, the timer does not advance and neither flag is set by events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read-back |
| cnt_hsec | input | 8 | Hundredths counter (BCD) |
| cnt_sec | input | 8 | Seconds counter |
| cnt_min | input | 8 | Minutes counter |
| cnt_hour | input | 8 | Hours counter with format bits 7:6 |
| cnt_date | input | 8 | Year 7:6, date 5:0 |
| cnt_wkmon | input | 8 | Weekday 7:5, month 4:0 |
| tick_hsec | input | 1 | One-cycle hundredths pulse |
| tick_sec | input | 1 | One-cycle seconds pulse |
| tick_min | input | 1 | One-cycle minutes pulse |
| tick_hour | input | 1 | One-cycle hours pulse |
| tick_day | input | 1 | One-cycle days pulse |
| irq_oe | output | 1 | 1 = pull interrupt line low |

## Verification
Register writes and timer steps become visible at the first clock edge after the stimulus, and `rd_data` and `irq_oe` follow combinationally from registers. A clock-alarm flag appears one edge after the counters start to match. A timer-alarm flag needs two edges after the tick: one to step the timer and one to latch the match. The bench drives on falling edges and reads on the falling edge after the edge where each result is due. For the timer alarm it also confirms that the flag is still clear one edge early.

// File: rtl/atc_pkg.sv
package atc_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_TMR  = 4'h7;
    localparam logic [ADDR_W-1:0] ADDR_ACTL = 4'h8;
    localparam int ALM_LO = 9;
    localparam int ALM_HI = 15;

    localparam logic [DATA_W-1:0] DATE_MASK  = 8'h3F;
    localparam logic [DATA_W-1:0] MONTH_MASK = 8'h1F;
    localparam logic [DATA_W-1:0] BCD_TOP    = 8'h99;

    typedef enum logic [1:0] {
        CAL_NONE    = 2'b00,
        CAL_DAILY   = 2'b01,
        CAL_WEEKDAY = 2'b10,
        CAL_DATED   = 2'b11
    } cal_e;

    typedef struct packed {
        logic       stop;
        logic       hold;
        logic [1:0] mode;
        logic       mask;
        logic       alm_en;
        logic       aflag;
        logic       tflag;
    } ctl_t;

    typedef struct packed {
        logic       a_irq_en;
        logic       tmr_alm_en;
        cal_e       cal;
        logic       t_irq_en;
        logic [2:0] tres;
    } actl_t;

    typedef struct packed {
        logic [DATA_W-1:0] hsec;
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] mins;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] date;
        logic [DATA_W-1:0] wkmon;
    } tfields_t;

    function automatic logic [DATA_W-1:0] bcd2_inc(input logic [DATA_W-1:0] v);
        logic [3:0] lo;
        logic [3:0] hi;
        lo = v[3:0];
        hi = v[7:4];
        if (lo >= 4'd9) begin
            lo = 4'd0;
            hi = (hi >= 4'd9) ? 4'd0 : hi + 4'd1;
        end else begin
            lo = lo + 4'd1;
        end
        return {hi, lo};
    endfunction
endpackage

// File: rtl/atc_timer.sv
module atc_timer
    import atc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] value,
    output logic              wrap
);
    assign wrap = step && !load && (value == BCD_TOP);

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (step) value <= bcd2_inc(value);
    end
endmodule

// File: rtl/atc_match.sv
module atc_match
    import atc_pkg::*;
(
    input  tfields_t cur,
    input  tfields_t alm,
    input  cal_e     cal,
    output logic     hit
);
    logic       tod_eq;
    logic       day_eq;
    logic [2:0] wd;
    logic       wd_ok;

    assign tod_eq = (cur.hsec == alm.hsec) && (cur.sec == alm.sec) &&
                    (cur.mins == alm.mins) && (cur.hour == alm.hour);
    assign day_eq = ((cur.date & DATE_MASK) == (alm.date & DATE_MASK)) &&
                    ((cur.wkmon & MONTH_MASK) == (alm.wkmon & MONTH_MASK));
    assign wd     = cur.wkmon[7:5];
    assign wd_ok  = (wd != 3'd7) && alm.wkmon[wd];

    always_comb begin
        unique case (cal)
            CAL_DAILY:   hit = tod_eq;
            CAL_WEEKDAY: hit = tod_eq && wd_ok;
            CAL_DATED:   hit = tod_eq && day_eq;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/atc_square.sv
module atc_square #(
    parameter int HSEC_PER_HALF    = 50,
    parameter int SEC_PER_HALF_MIN = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_hsec,
    input  logic tick_sec,
    output logic sec_phase,
    output logic min_phase
);
    localparam int HW = $clog2(HSEC_PER_HALF);
    localparam int SW = $clog2(SEC_PER_HALF_MIN);

    logic [HW-1:0] hcnt;
    logic [SW-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt      <= '0;
            sec_phase <= 1'b0;
        end else if (tick_hsec) begin
            if (hcnt == HW'(HSEC_PER_HALF - 1)) begin
                hcnt      <= '0;
                sec_phase <= !sec_phase;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scnt      <= '0;
            min_phase <= 1'b0;
        end else if (tick_sec) begin
            if (scnt == SW'(SEC_PER_HALF_MIN - 1)) begin
                scnt      <= '0;
                min_phase <= !min_phase;
            end else begin
                scnt <= scnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/alarm_timer_ctrl.sv
module alarm_timer_ctrl
    import atc_pkg::*;
#(
    parameter int HSEC_PER_HALF    = 50,
    parameter int SEC_PER_HALF_MIN = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] cnt_hsec,
    input  logic [DATA_W-1:0] cnt_sec,
    input  logic [DATA_W-1:0] cnt_min,
    input  logic [DATA_W-1:0] cnt_hour,
    input  logic [DATA_W-1:0] cnt_date,
    input  logic [DATA_W-1:0] cnt_wkmon,
    input  logic              tick_hsec,
    input  logic              tick_sec,
    input  logic              tick_min,
    input  logic              tick_hour,
    input  logic              tick_day,
    output logic              irq_oe
);
    ctl_t              ctl_q, ctl_n;
    actl_t             actl_q;
    logic [DATA_W-1:0] alm_q [ALM_LO:ALM_HI];
    logic [DATA_W-1:0] tmr_val;
    logic              tmr_step, tmr_load, tmr_wrap, tmr_tick;
    logic              clk_hit, clk_cond, tmr_cond;
    logic              clk_hit_q, tmr_hit_q;
    logic              aset, tset;
    logic              sec_phase, min_phase;
    tfields_t          cur_f, alm_f;

    // timer tick select by resolution code
    always_comb begin
        case (actl_q.tres)
            3'd1:    tmr_tick = tick_hsec;
            3'd2:    tmr_tick = tick_sec;
            3'd3:    tmr_tick = tick_min;
            3'd4:    tmr_tick = tick_hour;
            3'd5:    tmr_tick = tick_day;
            default: tmr_tick = 1'b0;
        endcase
    end

    assign tmr_step = ctl_q.alm_en && tmr_tick;
    assign tmr_load = wr_en && (wr_addr == ADDR_TMR);

    atc_timer u_timer (
        .clk(clk), .rst(rst), .step(tmr_step), .load(tmr_load),
        .load_val(wr_data), .value(tmr_val), .wrap(tmr_wrap)
    );

    assign cur_f = '{hsec: cnt_hsec, sec: cnt_sec, mins: cnt_min,
                     hour: cnt_hour, date: cnt_date, wkmon: cnt_wkmon};
    assign alm_f = '{hsec: alm_q[9], sec: alm_q[10], mins: alm_q[11],
                     hour: alm_q[12], date: alm_q[13], wkmon: alm_q[14]};

    atc_match u_match (.cur(cur_f), .alm(alm_f), .cal(actl_q.cal), .hit(clk_hit));

    atc_square #(
        .HSEC_PER_HALF(HSEC_PER_HALF), .SEC_PER_HALF_MIN(SEC_PER_HALF_MIN)
    ) u_square (
        .clk(clk), .rst(rst), .tick_hsec(tick_hsec), .tick_sec(tick_sec),
        .sec_phase(sec_phase), .min_phase(min_phase)
    );

    // events: rising edge of each match, overflow of the timer
    assign clk_cond = ctl_q.alm_en && clk_hit;
    assign tmr_cond = ctl_q.alm_en && actl_q.tmr_alm_en && (tmr_val == alm_q[ALM_HI]);
    assign aset     = (clk_cond && !clk_hit_q) || (tmr_cond && !tmr_hit_q);
    assign tset     = tmr_wrap;

    always_comb begin
        ctl_n = ctl_q;
        if (wr_en && (wr_addr == ADDR_CTL)) ctl_n = ctl_t'(wr_data);
        ctl_n.aflag = ctl_n.aflag || aset;
        ctl_n.tflag = ctl_n.tflag || tset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            actl_q    <= '0;
            clk_hit_q <= 1'b0;
            tmr_hit_q <= 1'b0;
            for (int i = ALM_LO; i <= ALM_HI; i++) alm_q[i] <= '0;
        end else begin
            ctl_q     <= ctl_n;
            clk_hit_q <= clk_cond;
            tmr_hit_q <= tmr_cond;
            if (wr_en && (wr_addr == ADDR_ACTL)) actl_q <= actl_t'(wr_data);
            for (int i = ALM_LO; i <= ALM_HI; i++)
                if (wr_en && (wr_addr == ADDR_W'(i))) alm_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTL)
            rd_data = ctl_q.alm_en ? ctl_q : {ctl_q[7:2], min_phase, sec_phase};
        else if (rd_addr == ADDR_TMR)
            rd_data = tmr_val;
        else if (rd_addr == ADDR_ACTL)
            rd_data = actl_q;
        for (int i = ALM_LO; i <= ALM_HI; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = alm_q[i];
    end

    assign irq_oe = ctl_q.alm_en
                  ? ((ctl_q.aflag && actl_q.a_irq_en) || (ctl_q.tflag && actl_q.t_irq_en))
                  : sec_phase;
endmodule

// File: rtl/atc_checker.sv
module atc_checker
    import atc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_oe,
    input logic              ae,
    input logic              aflag,
    input logic              tflag,
    input logic [DATA_W-1:0] timer,
    input logic              tmr_step,
    input logic              sec_phase,
    input logic              tick_hsec
);
    logic ctl_wr, tmr_wr;
    assign ctl_wr = wr_en && (wr_addr == ADDR_CTL);
    assign tmr_wr = wr_en && (wr_addr == ADDR_TMR);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (timer == 8'h00 && !irq_oe && !aflag && !tflag));

    // R5
    timer_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (timer == 8'h99 && tmr_step && !tmr_wr) |=> (timer == 8'h00 && tflag));

    // R11
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (aflag && !(ctl_wr && !wr_data[1])) |=> aflag);

    // R11
    timer_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tflag && !(ctl_wr && !wr_data[0])) |=> tflag);

    // R13
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ae && !ctl_wr && !tmr_wr) |=> ($stable(aflag) && $stable(tflag) && $stable(timer)));

    // R12
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        (ae && irq_oe) |-> (aflag || tflag));

    // R3
    square_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_hsec |=> $stable(sec_phase));
endmodule

bind alarm_timer_ctrl atc_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_oe(irq_oe), .ae(ctl_q.alm_en), .aflag(ctl_q.aflag), .tflag(ctl_q.tflag),
    .timer(tmr_val), .tmr_step(tmr_step), .sec_phase(sec_phase), .tick_hsec(tick_hsec)
);

// File: tb/tb_alarm_timer_ctrl.sv
`timescale 1ns/1ps
module tb_alarm_timer_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] c_hsec = 8'h10, c_sec = 8'h22, c_min = 8'h33, c_hour = 8'h14;
    logic [7:0] c_date = 8'h45, c_wkmon = 8'h63;
    logic [4:0] ticks = '0;   // 0 hsec, 1 sec, 2 min, 3 hour, 4 day
    logic       irq_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    alarm_timer_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_hsec(c_hsec), .cnt_sec(c_sec), .cnt_min(c_min), .cnt_hour(c_hour),
        .cnt_date(c_date), .cnt_wkmon(c_wkmon),
        .tick_hsec(ticks[0]), .tick_sec(ticks[1]), .tick_min(ticks[2]),
        .tick_hour(ticks[3]), .tick_day(ticks[4]), .irq_oe(irq_oe)
    );

    // start value, expected value after one seconds tick
    localparam logic [15:0] TMR_VEC [6] = '{16'h0001, 16'h0910, 16'h1920,
                                           16'h5859, 16'h8990, 16'h9899};

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic [4:0] t);
        @(negedge clk);
        ticks = t;
        @(negedge clk);
        ticks = '0;
    endtask

    task automatic set_hsec(input logic [7:0] v);
        @(negedge clk);
        c_hsec = v;
    endtask

    initial begin
        #(8 * 100000);
        $display("FAIL watchdog: got timeout expected completion");
        n_chk++;
        n_fail++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1", v, 8'h00);
        end
        check("R1 irq", {7'd0, irq_oe}, 8'h00);

        // R3 square wave while alarm disabled
        for (int i = 0; i < 49; i++) pulse(5'b00001);
        check("R3 before half", {7'd0, irq_oe}, 8'h00);
        pulse(5'b00001);
        check("R3 low half", {7'd0, irq_oe}, 8'h01);
        rd(4'h0, v);
        check("R3 sec phase", v, 8'h01);
        for (int i = 0; i < 50; i++) pulse(5'b00001);
        check("R3 back high", {7'd0, irq_oe}, 8'h00);
        for (int i = 0; i < 30; i++) pulse(5'b00010);
        rd(4'h0, v);
        check("R3 min phase", v, 8'h02);

        // R2 register access
        wr(4'h0, 8'hC4);
        rd(4'h0, v);
        check("R2 ctl", v, 8'hC4);
        wr(4'h0, 8'h04);
        wr(4'h8, 8'h02);
        rd(4'h8, v);
        check("R2 actl", v, 8'h02);
        wr(4'hD, 8'hA5);
        rd(4'hD, v);
        check("R2 alarm reg", v, 8'hA5);
        rd(4'h3, v);
        check("R1 unmapped", v, 8'h00);

        // R4 vector table: BCD step on seconds tick
        for (int i = 0; i < 6; i++) begin
            wr(4'h7, TMR_VEC[i][15:8]);
            pulse(5'b00010);
            rd(4'h7, v);
            check("R4 bcd step", v, TMR_VEC[i][7:0]);
        end
        pulse(5'b11101);
        rd(4'h7, v);
        check("R4 other ticks ignored", v, 8'h99);
        wr(4'h8, 8'h00);
        pulse(5'b11111);
        rd(4'h7, v);
        check("R4 resolution none", v, 8'h99);

        // R5 wrap
        wr(4'h8, 8'h01);
        pulse(5'b00001);
        rd(4'h7, v);
        check("R5 wrap value", v, 8'h00);
        rd(4'h0, v);
        check("R5 timer flag", v, 8'h05);
        wr(4'h0, 8'h04);

        // R6 load beats tick
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'h7; wr_data = 8'h42; ticks = 5'b00001;
        @(negedge clk);
        wr_en = 1'b0; ticks = '0;
        rd(4'h7, v);
        check("R6 load priority", v, 8'h42);

        // R10 timer alarm, two edges after the tick
        wr(4'hF, 8'h43);
        wr(4'h8, 8'h41);
        pulse(5'b00001);
        rd(4'h0, v);
        check("R10 not yet", v, 8'h04);
        @(negedge clk);
        rd(4'h0, v);
        check("R10 timer alarm", v, 8'h06);
        wr(4'h0, 8'h04);
        @(negedge clk);
        rd(4'h0, v);
        check("R11 persistent match", v, 8'h04);
        wr(4'h8, 8'h00);

        // R7 daily alarm
        wr(4'h9, 8'h11); wr(4'hA, 8'h22); wr(4'hB, 8'h33); wr(4'hC, 8'h14);
        wr(4'hD, 8'h07); wr(4'hE, 8'h09);
        wr(4'h8, 8'h10);
        rd(4'h0, v);
        check("R7 no match", v, 8'h04);
        set_hsec(8'h11);
        @(negedge clk);
        rd(4'h0, v);
        check("R7 daily", v, 8'h06);
        wr(4'h0, 8'h04);
        @(negedge clk);
        rd(4'h0, v);
        check("R11 cleared", v, 8'h04);

        // R11 event wins over a same-cycle clear
        set_hsec(8'h10);
        @(negedge clk);
        c_hsec = 8'h11; wr_en = 1'b1; wr_addr = 4'h0; wr_data = 8'h04;
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'h0, v);
        check("R11 set wins", v, 8'h06);

        // R8 dated alarm
        set_hsec(8'h10);
        wr(4'h0, 8'h04);
        wr(4'h8, 8'h30);
        wr(4'hD, 8'hC6);
        wr(4'hE, 8'h83);
        set_hsec(8'h11);
        @(negedge clk);
        rd(4'h0, v);
        check("R8 date differs", v, 8'h04);
        wr(4'hD, 8'hC5);
        @(negedge clk);
        rd(4'h0, v);
        check("R8 dated", v, 8'h06);

        // R9 weekday alarm
        set_hsec(8'h10);
        wr(4'h0, 8'h04);
        wr(4'h8, 8'h20);
        wr(4'hE, 8'h77);
        set_hsec(8'h11);
        @(negedge clk);
        rd(4'h0, v);
        check("R9 day disabled", v, 8'h04);
        set_hsec(8'h10);
        wr(4'hE, 8'h08);
        set_hsec(8'h11);
        @(negedge clk);
        rd(4'h0, v);
        check("R9 weekday", v, 8'h06);

        // R12 interrupt enables
        check("R12 masked", {7'd0, irq_oe}, 8'h00);
        wr(4'h8, 8'hA0);
        check("R12 alarm irq", {7'd0, irq_oe}, 8'h01);
        set_hsec(8'h10);
        wr(4'h0, 8'h04);
        check("R12 cleared", {7'd0, irq_oe}, 8'h00);
        wr(4'h8, 8'h01);
        wr(4'h7, 8'h99);
        pulse(5'b00001);
        check("R12 tflag masked", {7'd0, irq_oe}, 8'h00);
        wr(4'h8, 8'h09);
        check("R12 timer irq", {7'd0, irq_oe}, 8'h01);

        // R13 disabled freezes timer and flags
        wr(4'h0, 8'h00);
        pulse(5'b00001);
        wr(4'h0, 8'h04);
        rd(4'h7, v);
        check("R13 timer held", v, 8'h00);
        rd(4'h0, v);
        check("R13 no flags", v, 8'h04);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule